// File: doc/BRIEF.md
# Dual-Channel Burst Pulse Generator

This block drives two independent pulse outputs. Each channel has its own high time, low time and cycle count. Times are counted in ticks of a shared 100 µs timebase, which a prescaler makes by dividing the system clock by a parameter. Software sets a channel up by writing 16-bit words to command codes on a single write port. It then sets the channel's bit in a shared enable word. The channel emits the programmed number of high/low cycles, then parks low and reports that it has finished. A count of zero makes the channel run until it is disabled.

Every programmed word can be read back combinationally by presenting its command code on the read port. Each channel also reports on a dedicated output that its burst has finished.

Top module: `burst_pwm`

## Requirements
- R1: A timebase tick occurs once every `TICK_DIV` clock cycles. Every phase of the output lasts a whole number of ticks.
- R2: Writes decode as follows:
  - 0x10+2n sets the high time of channel n.
  - 0x11+2n sets the low time of channel n.
  - 0x14+n sets the cycle count of channel n.
  - 0x1F sets the enable word, where bit n enables channel n.
  - Presenting any of these codes on `rd_cmd_i` returns the stored word on `rd_data_o`. Every other code reads 0, and a write to any other code changes nothing.
- R3: Outputs change state only on a tick. After enable, a channel goes high at the first tick.
- R4: High lasts `hi` ticks and low lasts `lo` ticks. A stored time of 0 behaves as 1 tick.
- R5: A nonzero count N gives exactly N high pulses, each followed by its full low time.
- R6: After the last low time, `done_o[n]` is 1 and the output stays low. The enable bit stays set and reads back set.
- R7: A count of 0 repeats cycles without end, and `done_o[n]` never rises.
- R8: Clearing the enable bit drives the output low and clears `done_o[n]` by the cycle after the write. Setting it again restarts a full burst.
- R9: The channels are independent. A disabled channel stays low while the other one runs.
- R10: After reset, all stored words are 0 and both outputs and both done flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_cmd_i | input | 8 | Write command code |
| wr_data_i | input | 16 | Write data word |
| rd_cmd_i | input | 8 | Readback command code |
| rd_data_o | output | 16 | Readback word for `rd_cmd_i` |
| pwm_o | output | 2 | Pulse outputs, bit n is channel n |
| done_o | output | 2 | Burst finished, bit n is channel n |

## Verification
The bench measures every high and low run in clock cycles and compares each one to the programmed ticks times the divider. The zero-time cases would show up as a run of 0 cycles or 65536 ticks if the substitution were missing. An off-by-one in the cycle counter would give one pulse too many or too few before `done_o` rises, or would let `done_o` rise before the final low time ends. The bench disables a channel in mid-pulse, expecting the output to drop at once rather than finishing the phase. It re-enables a channel after a partial burst, expecting the full count again rather than the remainder. It also runs both channels together to catch crossed command decode or crossed enable bits.

// File: rtl/burst_pwm_pkg.sv
package burst_pwm_pkg;
  localparam int NUM_CH = 2;
  localparam int PW     = 16;

  localparam logic [7:0] CMD_HI_BASE    = 8'h10;
  localparam logic [7:0] CMD_LO_BASE    = 8'h11;
  localparam logic [7:0] CMD_BURST_BASE = 8'h14;
  localparam logic [7:0] CMD_EN_MASK    = 8'h1F;

  typedef enum logic [1:0] {ST_IDLE, ST_HIGH, ST_LOW, ST_DONE} ch_state_e;

  typedef struct packed {
    logic [PW-1:0] hi;
    logic [PW-1:0] lo;
    logic [PW-1:0] burst;
  } ch_cfg_t;
endpackage

// File: rtl/burst_pwm_tick.sv
module burst_pwm_tick #(
  parameter int TICK_DIV = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  p_div_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_tick_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/burst_pwm_cfg.sv
module burst_pwm_cfg
  import burst_pwm_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [7:0]               wr_cmd_i,
  input  logic [PW-1:0]            wr_data_i,
  input  logic [7:0]               rd_cmd_i,
  output logic [PW-1:0]            rd_data_o,
  output ch_cfg_t [NUM_CH-1:0]     cfg_o,
  output logic [NUM_CH-1:0]        en_o
);
  ch_cfg_t [NUM_CH-1:0] cfg_q;
  logic    [NUM_CH-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      en_q  <= '0;
    end else if (wr_en_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_cmd_i == CMD_HI_BASE + 8'(2*c))  cfg_q[c].hi    <= wr_data_i;
        if (wr_cmd_i == CMD_LO_BASE + 8'(2*c))  cfg_q[c].lo    <= wr_data_i;
        if (wr_cmd_i == CMD_BURST_BASE + 8'(c)) cfg_q[c].burst <= wr_data_i;
      end
      if (wr_cmd_i == CMD_EN_MASK) en_q <= wr_data_i[NUM_CH-1:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_cmd_i == CMD_HI_BASE + 8'(2*c))  rd_data_o = cfg_q[c].hi;
      if (rd_cmd_i == CMD_LO_BASE + 8'(2*c))  rd_data_o = cfg_q[c].lo;
      if (rd_cmd_i == CMD_BURST_BASE + 8'(c)) rd_data_o = cfg_q[c].burst;
    end
    if (rd_cmd_i == CMD_EN_MASK) rd_data_o = PW'(en_q);
  end

  assign cfg_o = cfg_q;
  assign en_o  = en_q;

  p_mask_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_cmd_i == CMD_EN_MASK) |=> $stable(en_q));
endmodule

// File: rtl/burst_pwm_chan.sv
module burst_pwm_chan
  import burst_pwm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    en_i,
  input  ch_cfg_t cfg_i,
  output logic    pwm_o,
  output logic    done_o
);
  ch_state_e     st_q;
  logic [PW-1:0] cnt_q, rem_q;
  logic          cont_q;
  logic [PW-1:0] hi_eff, lo_eff;

  // zero period is treated as one tick
  assign hi_eff = (cfg_i.hi == '0) ? PW'(1) : cfg_i.hi;
  assign lo_eff = (cfg_i.lo == '0) ? PW'(1) : cfg_i.lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rem_q  <= '0;
      cont_q <= 1'b0;
    end else if (!en_i) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rem_q  <= cfg_i.burst;
      cont_q <= 1'b0;
    end else if (tick_i) begin
      unique case (st_q)
        ST_IDLE: begin
          st_q   <= ST_HIGH;
          cnt_q  <= PW'(1);
          rem_q  <= cfg_i.burst;
          cont_q <= (cfg_i.burst == '0);
        end
        ST_HIGH: begin
          if (cnt_q >= hi_eff) begin
            st_q  <= ST_LOW;
            cnt_q <= PW'(1);
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_LOW: begin
          if (cnt_q >= lo_eff) begin
            cnt_q <= PW'(1);
            if (cont_q) st_q <= ST_HIGH;
            else if (rem_q <= PW'(1)) st_q <= ST_DONE;
            else begin
              rem_q <= rem_q - 1'b1;
              st_q  <= ST_HIGH;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign pwm_o  = en_i && (st_q == ST_HIGH);
  assign done_o = en_i && (st_q == ST_DONE);

  p_edge_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && (pwm_o != $past(pwm_o))) |-> $past(tick_i));
  p_rem_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_HIGH || st_q == ST_LOW) && !cont_q) |-> (rem_q != '0));
  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE && en_i) |=> (st_q == ST_DONE));
  p_cont_no_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_q |-> (st_q != ST_DONE));
  p_off_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (st_q == ST_IDLE));
endmodule

// File: rtl/burst_pwm.sv
module burst_pwm
  import burst_pwm_pkg::*;
#(
  parameter int TICK_DIV = 20000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  wr_cmd_i,
  input  logic [15:0] wr_data_i,
  input  logic [7:0]  rd_cmd_i,
  output logic [15:0] rd_data_o,
  output logic [1:0]  pwm_o,
  output logic [1:0]  done_o
);
  logic                 tick;
  ch_cfg_t [NUM_CH-1:0] cfg;
  logic    [NUM_CH-1:0] en;

  burst_pwm_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  burst_pwm_cfg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_cmd_i (wr_cmd_i),
    .wr_data_i(wr_data_i),
    .rd_cmd_i (rd_cmd_i),
    .rd_data_o(rd_data_o),
    .cfg_o    (cfg),
    .en_o     (en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    burst_pwm_chan u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .en_i  (en[c]),
      .cfg_i (cfg[c]),
      .pwm_o (pwm_o[c]),
      .done_o(done_o[c])
    );
  end

  p_done_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(done_o & pwm_o) == 0);
endmodule

// File: tb/burst_pwm_bench.sv
module burst_pwm_bench;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_cmd = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_cmd = '0;
  logic [15:0] rd_data;
  logic [1:0]  pwm, done;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  burst_pwm #(.TICK_DIV(DIV)) u_burst_pwm (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_cmd_i(wr_cmd),
    .wr_data_i(wr_data), .rd_cmd_i(rd_cmd), .rd_data_o(rd_data),
    .pwm_o(pwm), .done_o(done)
  );

  // fields: ch[55:48] hi[47:32] lo[31:16] burst[15:0]
  localparam logic [55:0] VEC [5] = '{
    56'h00_0003_0002_0004,
    56'h01_0001_0001_0003,
    56'h00_0000_0005_0002,
    56'h01_0006_0000_0001,
    56'h00_0002_0007_0001
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] c, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_cmd = c; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] c, output int v);
    rd_cmd = c;
    #1;
    v = int'(rd_data);
  endtask

  task automatic run_burst(input int ch, input int ehi, input int elo, input int limit,
                           output int pulses, output int bad, output bit seen_done,
                           output bit other_hi);
    bit prev = 1'b0;
    int run = 0;
    pulses = 0; bad = 0; seen_done = 1'b0; other_hi = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done[ch]) begin
        seen_done = 1'b1;
        if (run != elo*DIV) bad++;
        break;
      end
      if (pwm[1-ch]) other_hi = 1'b1;
      if (pwm[ch] != prev) begin
        if (prev) begin
          if (run != ehi*DIV) bad++;
          pulses++;
        end else if (pulses > 0 && run != elo*DIV) bad++;
        run = 1;
      end else run++;
      prev = pwm[ch];
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, pulses, bad, lim, ch, hi, lo, burst, he, le, r0, r1;
    bit sd, oh, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check(pwm == 2'b00, "R10 pwm", int'(pwm), 0);
    check(done == 2'b00, "R10 done", int'(done), 0);
    foreach (VEC[i]) begin end
    for (int c = 8'h10; c <= 8'h15; c++) begin
      rd(8'(c), v);
      check(v == 0, "R10 reg", v, 0);
    end
    rd(8'h1F, v);
    check(v == 0, "R10 mask", v, 0);

    // R2 unknown codes ignored
    wr(8'h16, 16'hFFFF);
    wr(8'h1E, 16'hFFFF);
    rd(8'h16, v); check(v == 0, "R2 unknown rd", v, 0);
    rd(8'h1F, v); check(v == 0, "R2 mask untouched", v, 0);
    rd(8'h14, v); check(v == 0, "R2 burst untouched", v, 0);
    repeat (4*DIV) @(negedge clk);
    check(pwm == 2'b00, "R2 no output", int'(pwm), 0);

    // vector table: R2 R3 R4 R5 R6 R9
    foreach (VEC[i]) begin
      ch = int'(VEC[i][55:48]); hi = int'(VEC[i][47:32]);
      lo = int'(VEC[i][31:16]); burst = int'(VEC[i][15:0]);
      he = (hi == 0) ? 1 : hi; le = (lo == 0) ? 1 : lo;
      wr(8'(8'h10 + 2*ch), 16'(hi));
      wr(8'(8'h11 + 2*ch), 16'(lo));
      wr(8'(8'h14 + ch), 16'(burst));
      rd(8'(8'h10 + 2*ch), v); check(v == hi, "R2 hi rd", v, hi);
      rd(8'(8'h11 + 2*ch), v); check(v == lo, "R2 lo rd", v, lo);
      rd(8'(8'h14 + ch), v);   check(v == burst, "R2 burst rd", v, burst);
      wr(8'h1F, 16'(1 << ch));
      lim = (he + le) * burst * DIV + 4*DIV + 10;
      run_burst(ch, he, le, lim, pulses, bad, sd, oh);
      check(bad == 0, "R4 widths", bad, 0);
      check(pulses == burst, "R5 pulse count", pulses, burst);
      check(sd, "R6 done", int'(sd), 1);
      check(!oh, "R9 other low", int'(oh), 0);
      rd(8'h1F, v); check(v == (1 << ch), "R6 enable kept", v, 1 << ch);
      repeat (3*DIV) @(negedge clk);
      check(pwm[ch] == 1'b0 && done[ch], "R6 parked low", int'(pwm[ch]), 0);
      wr(8'h1F, 16'h0000);
      check(done == 2'b00, "R8 done cleared", int'(done), 0);
    end

    // R7 continuous
    wr(8'h10, 16'd2); wr(8'h11, 16'd1); wr(8'h14, 16'd0);
    wr(8'h1F, 16'h0001);
    pulses = 0; seen = 1'b0;
    for (int i = 0, p = 0; i < 30*3*DIV; i++) begin
      @(negedge clk);
      if (pwm[0] && !p) pulses++;
      if (done[0]) seen = 1'b1;
      p = pwm[0];
    end
    check(pulses >= 25, "R7 keeps running", pulses, 25);
    check(!seen, "R7 never done", int'(seen), 0);

    // R8 disable in mid-high
    while (!pwm[0]) @(negedge clk);
    wr(8'h1F, 16'h0000);
    check(pwm[0] == 1'b0, "R8 forced low", int'(pwm[0]), 0);
    repeat (3*DIV) @(negedge clk);
    check(pwm[0] == 1'b0, "R8 stays low", int'(pwm[0]), 0);

    // R8 restart gives full burst
    wr(8'h10, 16'd1); wr(8'h11, 16'd1); wr(8'h14, 16'd3);
    wr(8'h1F, 16'h0001);
    while (!pwm[0]) @(negedge clk);
    while (pwm[0]) @(negedge clk);
    wr(8'h1F, 16'h0000);
    wr(8'h1F, 16'h0001);
    run_burst(0, 1, 1, 2*3*DIV + 4*DIV + 10, pulses, bad, sd, oh);
    check(pulses == 3 && sd, "R8 full restart", pulses, 3);
    wr(8'h1F, 16'h0000);

    // R9 both channels together
    wr(8'h10, 16'd2); wr(8'h11, 16'd2); wr(8'h14, 16'd2);
    wr(8'h12, 16'd1); wr(8'h13, 16'd3); wr(8'h15, 16'd3);
    wr(8'h1F, 16'h0003);
    r0 = 0; r1 = 0;
    for (int i = 0, p0 = 0, p1 = 0; i < 20*DIV + 40; i++) begin
      @(negedge clk);
      if (pwm[0] && !p0) r0++;
      if (pwm[1] && !p1) r1++;
      p0 = pwm[0]; p1 = pwm[1];
      if (done == 2'b11) break;
    end
    check(r0 == 2, "R9 ch0 count", r0, 2);
    check(r1 == 3, "R9 ch1 count", r1, 3);
    check(done == 2'b11, "R9 both done", int'(done), 3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule